// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block holds the two data queues that sit between a host register port and a serial shift engine. The host fills a transmit queue by writing a data register. The shift engine drains that queue through a pop port. In the other direction the shift engine fills a receive queue through a push port, and the host drains it by reading a data register. Each queue is 16 words deep by default. A packed status word reports each queue's fill level, whether the transmit queue is full and whether the receive queue is empty.

Queue conditions and errors are latched as sticky flags in one group, and the engine's completion pulses are latched in a second group. The conditions are the fill thresholds, receive full, transmit empty, transmit overflow and receive underrun. Each group has a matching enable register. A single interrupt line is raised whenever any latched flag in either group has its enable bit set. Software clears flags by writing ones to them. A control register flushes either queue without disturbing the other queue.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: While reset is held, both queues are empty, all flags, enables and the threshold code read as zero, and `irq` is low. The status word therefore reads 0x0010_0000.
- R2: A host write to word address 2 pushes the data into the transmit queue, and `eng_tx_pop` removes the oldest word. `eng_tx_data` always shows the oldest word, or zero when the queue is empty. The status word at address 4 holds the transmit full bit at bit 4, the transmit level at bits 15:8, the receive empty bit at bit 20 and the receive level at bits 31:24.
- R3: A host push while the transmit queue already holds DEPTH words is dropped, so the level and contents stay unchanged. The same clock edge sets the transmit overflow flag at bit 17 of the queue-flag register at address 5.
- R4: A host read of address 3 with `reg_rd` high pops the oldest receive word. If the receive queue is empty, the read returns zero, leaves the level at zero and sets the receive underrun flag at bit 16.
- R5: The threshold code in bits 1:0 of address 1 selects the limit: 0 gives 8 words, 1 gives 4 words, and 2 or 3 give 1 word. Whenever the registered transmit level is at or below the limit, the transmit threshold flag (bit 5) is set. Whenever the registered receive level is at or above the limit, the receive threshold flag (bit 4) is set.
- R6: An engine push while the receive queue holds DEPTH words is dropped. The receive full flag (bit 8) is set whenever the receive level equals DEPTH, and the transmit empty flag (bit 9) is set whenever the transmit level is zero. Receive words come out in arrival order.
- R7: Flags stay set until cleared. Writing to address 5 (queue flags) or address 7 (transfer flags) clears each flag whose data bit is one, so writing all ones clears the whole group. A set condition in the same cycle as the clear write wins, and the flag stays set.
- R8: A pulse on `xfer_rx_done` sets transfer flag bit 0, and a pulse on `xfer_tx_done` sets transfer flag bit 1. Both flags are read at address 7.
- R9: `irq` is high exactly when some queue flag has its bit set in the enable register at address 6, or some transfer flag has its bit set in the enable register at address 8.
- R10: Writing address 0 with bit 0 set empties the transmit queue, and writing it with bit 1 set empties the receive queue. Each flush leaves the other queue's contents and level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | ADDR_W | Register write word address |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Read strobe; pops the receive queue when the read address is 3 |
| reg_raddr | input | ADDR_W | Register read word address |
| reg_rdata | output | 32 | Register read data, combinational from the read address |
| eng_tx_pop | input | 1 | Shift engine takes the oldest transmit word |
| eng_tx_data | output | DATA_W | Oldest transmit word, zero when the queue is empty |
| eng_rx_push | input | 1 | Shift engine delivers a received word |
| eng_rx_data | input | DATA_W | Received word |
| xfer_rx_done | input | 1 | Receive completion pulse |
| xfer_tx_done | input | 1 | Transmit completion pulse |
| irq | output | 1 | Masked interrupt request |

## Verification
A wrong queue pointer or count appears at the ports on the very next cycle. It shows as a changed level field in the status word, a wrong `eng_tx_data` head, or a wrong word returned by a receive read. A corrupted flag or enable bit appears one cycle after the event that should have set it, either in the flag read-back or on `irq`. Comparing every output against a queue-based model on every clock therefore catches a fault within one or two cycles of its cause. Directed checks cover the full and empty boundaries, each threshold code, and clears that coincide with set conditions.

// File: rtl/sfiu_pkg.sv
package sfiu_pkg;

   localparam int REG_W = 32;

   // register word addresses
   localparam logic [3:0] A_CTRL = 4'd0;
   localparam logic [3:0] A_CFG  = 4'd1;
   localparam logic [3:0] A_TXD  = 4'd2;
   localparam logic [3:0] A_RXD  = 4'd3;
   localparam logic [3:0] A_STAT = 4'd4;
   localparam logic [3:0] A_FFL  = 4'd5;
   localparam logic [3:0] A_FEN  = 4'd6;
   localparam logic [3:0] A_XFL  = 4'd7;
   localparam logic [3:0] A_XEN  = 4'd8;

   // control bits
   localparam int CTRL_TX_FLUSH = 0;
   localparam int CTRL_RX_FLUSH = 1;

   // status word positions
   localparam int ST_TXFULL  = 4;
   localparam int ST_TXLVL   = 8;
   localparam int ST_RXEMPTY = 20;
   localparam int ST_RXLVL   = 24;
   localparam int ST_LVL_W   = 8;

   // threshold codes
   localparam logic [1:0] THR_8 = 2'd0;
   localparam logic [1:0] THR_4 = 2'd1;

   // compact queue flag indices and their register bit positions
   localparam int FI_RXTH  = 0;
   localparam int FI_TXTH  = 1;
   localparam int FI_RXFUL = 2;
   localparam int FI_TXEMP = 3;
   localparam int FI_RXUND = 4;
   localparam int FI_TXOVF = 5;
   localparam int FIFO_N   = 6;
   localparam int unsigned FIFO_POS [FIFO_N] = '{4, 5, 8, 9, 16, 17};

   localparam int XFER_N = 2;

endpackage

// File: rtl/sfiu_fifo.sv
module sfiu_fifo #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LVL_W = $clog2(DEPTH + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic [LVL_W-1:0]  level,
   output logic              full,
   output logic              empty
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("sfiu_fifo: DEPTH must be at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [LVL_W-1:0]  count;
   logic              push_ok, pop_ok;

   assign full    = (count == LVL_W'(DEPTH));
   assign empty   = (count == '0);
   assign level   = count;
   assign push_ok = push & ~full & ~flush;
   assign pop_ok  = pop & ~empty & ~flush;

   // pointer advance: free wrap for power-of-two depths, compare otherwise
   if ((1 << PTR_W) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= push_data;
   end

   assign head = empty ? '0 : mem[rd_ptr];

endmodule

// File: rtl/sfiu_thresh.sv
module sfiu_thresh
   import sfiu_pkg::*;
#(
   parameter int LVL_W = 5
)(
   input  logic [1:0]       sel,
   input  logic [LVL_W-1:0] tx_level,
   input  logic [LVL_W-1:0] rx_level,
   output logic             tx_low,
   output logic             rx_high
);

   if (LVL_W < 4) begin : g_bad_width
      $error("sfiu_thresh: level width too small for an 8-word limit");
   end

   logic [LVL_W-1:0] limit;

   always_comb begin
      case (sel)
         THR_8:   limit = LVL_W'(8);
         THR_4:   limit = LVL_W'(4);
         default: limit = LVL_W'(1);
      endcase
   end

   assign tx_low  = (tx_level <= limit);
   assign rx_high = (rx_level >= limit);

endmodule

// File: rtl/sfiu_flag_group.sv
module sfiu_flag_group #(
   parameter int W = 2
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_ev,
   input  logic         clr_we,
   input  logic [W-1:0] clr_bits,
   input  logic         en_we,
   input  logic [W-1:0] en_bits,
   output logic [W-1:0] flags,
   output logic [W-1:0] enables,
   output logic         hit
);

   if (W < 1) begin : g_bad_w
      $error("sfiu_flag_group: W must be positive");
   end

   logic [W-1:0] clr_mask;
   assign clr_mask = clr_we ? clr_bits : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags   <= '0;
         enables <= '0;
      end else begin
         // a set event overrides a clear in the same cycle
         flags <= (flags & ~clr_mask) | set_ev;
         if (en_we) enables <= en_bits;
      end
   end

   assign hit = |(flags & enables);

endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
   import sfiu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   parameter int ADDR_W = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_waddr,
   input  logic [31:0]       reg_wdata,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_raddr,
   output logic [31:0]       reg_rdata,
   input  logic              eng_tx_pop,
   output logic [DATA_W-1:0] eng_tx_data,
   input  logic              eng_rx_push,
   input  logic [DATA_W-1:0] eng_rx_data,
   input  logic              xfer_rx_done,
   input  logic              xfer_tx_done,
   output logic              irq
);

   localparam int LVL_W = $clog2(DEPTH + 1);

   if (DEPTH < 8) begin : g_bad_depth
      $error("spi_fifo_irq_unit: DEPTH must cover the 8-word threshold");
   end
   if (LVL_W > ST_LVL_W) begin : g_bad_lvl
      $error("spi_fifo_irq_unit: level does not fit the status field");
   end
   if (DATA_W < 1 || DATA_W > REG_W) begin : g_bad_data
      $error("spi_fifo_irq_unit: DATA_W must be 1..32");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("spi_fifo_irq_unit: ADDR_W must be at least 4");
   end

   // ---------------- address decode ----------------
   logic wr_ctrl, wr_cfg, wr_txd, wr_ffl, wr_fen, wr_xfl, wr_xen, rd_rxd;

   assign wr_ctrl = reg_wr && (reg_waddr == ADDR_W'(A_CTRL));
   assign wr_cfg  = reg_wr && (reg_waddr == ADDR_W'(A_CFG));
   assign wr_txd  = reg_wr && (reg_waddr == ADDR_W'(A_TXD));
   assign wr_ffl  = reg_wr && (reg_waddr == ADDR_W'(A_FFL));
   assign wr_fen  = reg_wr && (reg_waddr == ADDR_W'(A_FEN));
   assign wr_xfl  = reg_wr && (reg_waddr == ADDR_W'(A_XFL));
   assign wr_xen  = reg_wr && (reg_waddr == ADDR_W'(A_XEN));
   assign rd_rxd  = reg_rd && (reg_raddr == ADDR_W'(A_RXD));

   logic tx_flush, rx_flush;
   assign tx_flush = wr_ctrl & reg_wdata[CTRL_TX_FLUSH];
   assign rx_flush = wr_ctrl & reg_wdata[CTRL_RX_FLUSH];

   // ---------------- threshold code ----------------
   logic [1:0] thr_sel;

   always_ff @(posedge clk) begin
      if (!rst_n)      thr_sel <= THR_8;
      else if (wr_cfg) thr_sel <= reg_wdata[1:0];
   end

   // ---------------- queues ----------------
   logic [DATA_W-1:0] tx_head, rx_head;
   logic [LVL_W-1:0]  tx_level, rx_level;
   logic              tx_full, tx_empty, rx_full, rx_empty;

   sfiu_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (tx_flush),
      .push      (wr_txd),
      .push_data (reg_wdata[DATA_W-1:0]),
      .pop       (eng_tx_pop),
      .head      (tx_head),
      .level     (tx_level),
      .full      (tx_full),
      .empty     (tx_empty)
   );

   sfiu_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (rx_flush),
      .push      (eng_rx_push),
      .push_data (eng_rx_data),
      .pop       (rd_rxd),
      .head      (rx_head),
      .level     (rx_level),
      .full      (rx_full),
      .empty     (rx_empty)
   );

   assign eng_tx_data = tx_head;

   logic tx_low, rx_high;

   sfiu_thresh #(.LVL_W(LVL_W)) u_thr (
      .sel      (thr_sel),
      .tx_level (tx_level),
      .rx_level (rx_level),
      .tx_low   (tx_low),
      .rx_high  (rx_high)
   );

   // ---------------- queue flag group ----------------
   logic [FIFO_N-1:0] f_set, f_clr, f_en_in, fifo_flags, fifo_en;
   logic              f_hit;

   always_comb begin
      f_set           = '0;
      f_set[FI_RXTH]  = rx_high;
      f_set[FI_TXTH]  = tx_low;
      f_set[FI_RXFUL] = rx_full;
      f_set[FI_TXEMP] = tx_empty;
      f_set[FI_RXUND] = rd_rxd & rx_empty;
      f_set[FI_TXOVF] = wr_txd & tx_full;
   end

   for (genvar g = 0; g < FIFO_N; g++) begin : g_fmap
      assign f_clr[g]   = reg_wdata[FIFO_POS[g]];
      assign f_en_in[g] = reg_wdata[FIFO_POS[g]];
   end

   sfiu_flag_group #(.W(FIFO_N)) u_fgrp (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_ev   (f_set),
      .clr_we   (wr_ffl),
      .clr_bits (f_clr),
      .en_we    (wr_fen),
      .en_bits  (f_en_in),
      .flags    (fifo_flags),
      .enables  (fifo_en),
      .hit      (f_hit)
   );

   // ---------------- transfer flag group ----------------
   logic [XFER_N-1:0] x_set, xfer_flags, xfer_en;
   logic              x_hit;

   assign x_set = {xfer_tx_done, xfer_rx_done};

   sfiu_flag_group #(.W(XFER_N)) u_xgrp (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_ev   (x_set),
      .clr_we   (wr_xfl),
      .clr_bits (reg_wdata[XFER_N-1:0]),
      .en_we    (wr_xen),
      .en_bits  (reg_wdata[XFER_N-1:0]),
      .flags    (xfer_flags),
      .enables  (xfer_en),
      .hit      (x_hit)
   );

   assign irq = f_hit | x_hit;

   // ---------------- read path ----------------
   logic [31:0] stat_word, ffl_word, fen_word;

   always_comb begin
      stat_word = '0;
      stat_word[ST_TXFULL]                = tx_full;
      stat_word[ST_TXLVL +: ST_LVL_W]     = ST_LVL_W'(tx_level);
      stat_word[ST_RXEMPTY]               = rx_empty;
      stat_word[ST_RXLVL +: ST_LVL_W]     = ST_LVL_W'(rx_level);
      ffl_word = '0;
      fen_word = '0;
      for (int i = 0; i < FIFO_N; i++) begin
         ffl_word[FIFO_POS[i]] = fifo_flags[i];
         fen_word[FIFO_POS[i]] = fifo_en[i];
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_raddr)
         ADDR_W'(A_CFG):  reg_rdata[1:0]        = thr_sel;
         ADDR_W'(A_RXD):  reg_rdata[DATA_W-1:0] = rx_head;
         ADDR_W'(A_STAT): reg_rdata             = stat_word;
         ADDR_W'(A_FFL):  reg_rdata             = ffl_word;
         ADDR_W'(A_FEN):  reg_rdata             = fen_word;
         ADDR_W'(A_XFL):  reg_rdata[XFER_N-1:0] = xfer_flags;
         ADDR_W'(A_XEN):  reg_rdata[XFER_N-1:0] = xfer_en;
         default:         reg_rdata             = '0;
      endcase
   end

endmodule

// File: rtl/sfiu_checker.sv
module sfiu_checker
   import sfiu_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int ADDR_W = 4,
   parameter int LVL_W  = 5
)(
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_waddr,
   input logic [1:0]        wdata_lo,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_raddr,
   input logic [31:0]       reg_rdata,
   input logic              eng_tx_pop,
   input logic              eng_rx_push,
   input logic              xfer_rx_done,
   input logic              xfer_tx_done,
   input logic              irq,
   input logic [LVL_W-1:0]  tx_level,
   input logic [LVL_W-1:0]  rx_level,
   input logic [FIFO_N-1:0] fifo_flags,
   input logic [XFER_N-1:0] xfer_flags,
   input logic [FIFO_N-1:0] fifo_en,
   input logic [XFER_N-1:0] xfer_en
);

   logic push_tx, pop_rx, wr_ctl, clr_f, clr_x;
   assign push_tx = reg_wr && (reg_waddr == ADDR_W'(A_TXD));
   assign pop_rx  = reg_rd && (reg_raddr == ADDR_W'(A_RXD));
   assign wr_ctl  = reg_wr && (reg_waddr == ADDR_W'(A_CTRL));
   assign clr_f   = reg_wr && (reg_waddr == ADDR_W'(A_FFL));
   assign clr_x   = reg_wr && (reg_waddr == ADDR_W'(A_XFL));

   assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level <= LVL_W'(DEPTH)) && (rx_level <= LVL_W'(DEPTH)));

   assert_ovf_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (push_tx && tx_level == LVL_W'(DEPTH)) |=> fifo_flags[FI_TXOVF]);

   assert_ovf_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (push_tx && tx_level == LVL_W'(DEPTH) && !eng_tx_pop) |=> $stable(tx_level));

   assert_underrun_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_rx && rx_level == '0) |-> (reg_rdata == 32'h0));

   assert_rx_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_rx_push && rx_level == LVL_W'(DEPTH) && !pop_rx && !wr_ctl) |=> $stable(rx_level));

   assert_fifo_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_f |=> ((fifo_flags & $past(fifo_flags)) == $past(fifo_flags)));

   assert_xfer_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_x |=> ((xfer_flags & $past(xfer_flags)) == $past(xfer_flags)));

   assert_rx_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_rx_done |=> xfer_flags[0]);

   assert_tx_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_tx_done |=> xfer_flags[1]);

   assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en == '0 && xfer_en == '0) |-> !irq);

   assert_tx_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && wdata_lo[0]) |=> (tx_level == '0));

   assert_rx_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && wdata_lo[1]) |=> (rx_level == '0));

endmodule

bind spi_fifo_irq_unit sfiu_checker #(
   .DEPTH  (DEPTH),
   .ADDR_W (ADDR_W),
   .LVL_W  (LVL_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_wr       (reg_wr),
   .reg_waddr    (reg_waddr),
   .wdata_lo     (reg_wdata[1:0]),
   .reg_rd       (reg_rd),
   .reg_raddr    (reg_raddr),
   .reg_rdata    (reg_rdata),
   .eng_tx_pop   (eng_tx_pop),
   .eng_rx_push  (eng_rx_push),
   .xfer_rx_done (xfer_rx_done),
   .xfer_tx_done (xfer_tx_done),
   .irq          (irq),
   .tx_level     (tx_level),
   .rx_level     (rx_level),
   .fifo_flags   (fifo_flags),
   .xfer_flags   (xfer_flags),
   .fifo_en      (fifo_en),
   .xfer_en      (xfer_en)
);

// File: tb/sim_spi_fifo_irq_unit.sv
module sim_spi_fifo_irq_unit;

   localparam int          DW    = 32;
   localparam int          DEP   = 16;
   localparam int          AW    = 4;
   localparam logic [31:0] FMASK = 32'h0003_0330;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_waddr = '0;
   logic [31:0]   reg_wdata = '0;
   logic          reg_rd = 1'b0;
   logic [AW-1:0] reg_raddr = '0;
   logic [31:0]   reg_rdata;
   logic          eng_tx_pop = 1'b0;
   logic [DW-1:0] eng_tx_data;
   logic          eng_rx_push = 1'b0;
   logic [DW-1:0] eng_rx_data = '0;
   logic          xfer_rx_done = 1'b0;
   logic          xfer_tx_done = 1'b0;
   logic          irq;

   always #5 clk = ~clk;

   spi_fifo_irq_unit #(.DATA_W(DW), .DEPTH(DEP), .ADDR_W(AW)) u0 (
      .clk, .rst_n, .reg_wr, .reg_waddr, .reg_wdata, .reg_rd, .reg_raddr,
      .reg_rdata, .eng_tx_pop, .eng_tx_data, .eng_rx_push, .eng_rx_data,
      .xfer_rx_done, .xfer_tx_done, .irq
   );

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   task automatic check_eq(string req, string what, logic [31:0] got, logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got 0x%08h expected 0x%08h at %0t", req, what, got, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [31:0] tq[$];
   logic [31:0] rq[$];
   logic [31:0] m_ff = '0, m_fe = '0, m_xf = '0, m_xe = '0;
   logic [1:0]  m_thr = '0;

   function automatic int thr_words(logic [1:0] c);
      if (c == 2'd0) return 8;
      if (c == 2'd1) return 4;
      return 1;
   endfunction

   function automatic logic [31:0] m_rdata(logic [AW-1:0] a);
      logic [31:0] s;
      s = '0;
      case (a)
         4'd1: s = {30'b0, m_thr};
         4'd3: s = (rq.size() > 0) ? rq[0] : 32'h0;
         4'd4: begin
            s[4]     = (tq.size() == DEP);
            s[15:8]  = 8'(tq.size());
            s[20]    = (rq.size() == 0);
            s[31:24] = 8'(rq.size());
         end
         4'd5: s = m_ff;
         4'd6: s = m_fe;
         4'd7: s = m_xf;
         4'd8: s = m_xe;
         default: s = '0;
      endcase
      return s;
   endfunction

   always @(posedge clk) begin
      int tl, rl, th;
      logic [31:0] fset, fclr, xclr;
      cyc++;
      if (!rst_n) begin
         tq.delete(); rq.delete();
         m_ff = '0; m_fe = '0; m_xf = '0; m_xe = '0; m_thr = '0;
      end else begin
         tl = tq.size(); rl = rq.size(); th = thr_words(m_thr);
         fset = '0;
         if (reg_wr && reg_waddr == 4'd2 && tl == DEP) fset[17] = 1'b1;
         if (reg_rd && reg_raddr == 4'd3 && rl == 0)   fset[16] = 1'b1;
         if (tl <= th)  fset[5] = 1'b1;
         if (rl >= th)  fset[4] = 1'b1;
         if (rl == DEP) fset[8] = 1'b1;
         if (tl == 0)   fset[9] = 1'b1;
         fclr = (reg_wr && reg_waddr == 4'd5) ? reg_wdata : 32'h0;
         xclr = (reg_wr && reg_waddr == 4'd7) ? reg_wdata : 32'h0;
         m_ff = ((m_ff & ~fclr) | fset) & FMASK;
         m_xf = ((m_xf & ~xclr) | {30'b0, xfer_tx_done, xfer_rx_done}) & 32'h3;
         if (reg_wr && reg_waddr == 4'd6) m_fe = reg_wdata & FMASK;
         if (reg_wr && reg_waddr == 4'd8) m_xe = reg_wdata & 32'h3;
         if (reg_wr && reg_waddr == 4'd1) m_thr = reg_wdata[1:0];
         if (reg_wr && reg_waddr == 4'd0 && reg_wdata[0]) tq.delete();
         else begin
            if (eng_tx_pop && tl > 0) void'(tq.pop_front());
            if (reg_wr && reg_waddr == 4'd2 && tl < DEP) tq.push_back(reg_wdata);
         end
         if (reg_wr && reg_waddr == 4'd0 && reg_wdata[1]) rq.delete();
         else begin
            if (reg_rd && reg_raddr == 4'd3 && rl > 0) void'(rq.pop_front());
            if (eng_rx_push && rl < DEP) rq.push_back(eng_rx_data);
         end
      end
      if (cyc > 20000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, got cycle %0d expected under 20000", cyc);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   // per-cycle comparison, away from the clock edges
   always @(negedge clk) begin
      string rq_tag;
      #2;
      case (reg_raddr)
         4'd3:    rq_tag = "R6";
         4'd4:    rq_tag = "R2";
         4'd5:    rq_tag = "R7";
         4'd7:    rq_tag = "R8";
         default: rq_tag = "R1";
      endcase
      check_eq("R9", "irq", {31'b0, irq}, {31'b0, (|(m_ff & m_fe)) || (|(m_xf & m_xe))});
      check_eq("R2", "eng_tx_data", eng_tx_data, (tq.size() > 0) ? tq[0] : 32'h0);
      check_eq(rq_tag, "reg_rdata", reg_rdata, m_rdata(reg_raddr));
   end

   // ---------------- stimulus ----------------
   task automatic wr(logic [3:0] a, logic [31:0] d);
      reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic eng_pop();
      eng_tx_pop = 1'b1;
      @(negedge clk);
      eng_tx_pop = 1'b0;
   endtask

   task automatic eng_push(logic [31:0] d);
      eng_rx_push = 1'b1; eng_rx_data = d;
      @(negedge clk);
      eng_rx_push = 1'b0;
   endtask

   task automatic rx_read(output logic [31:0] v);
      reg_raddr = 4'd3; reg_rd = 1'b1;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic peek(logic [3:0] a, output logic [31:0] v);
      reg_raddr = a;
      #1 v = reg_rdata;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [31:0] v;
      @(negedge clk);
      @(negedge clk);
      peek(4'd4, v);
      check_eq("R1", "status in reset", v, 32'h0010_0000);
      check_eq("R1", "irq in reset", {31'b0, irq}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2: ordering and status fields
      wr(4'd2, 32'h11); wr(4'd2, 32'h22); wr(4'd2, 32'h33);
      peek(4'd4, v);
      check_eq("R2", "status after 3 pushes", v, 32'h0010_0300);
      check_eq("R2", "tx head", eng_tx_data, 32'h11);
      eng_pop();
      check_eq("R2", "tx head after pop", eng_tx_data, 32'h22);

      // R3: fill and overflow
      for (int i = 0; i < 14; i++) wr(4'd2, 32'h100 + i);
      peek(4'd4, v);
      check_eq("R3", "status full", v, 32'h0010_1010);
      wr(4'd2, 32'hDEAD);
      peek(4'd5, v);
      check_eq("R3", "overflow flag", (v >> 17) & 32'h1, 32'h1);
      peek(4'd4, v);
      check_eq("R3", "level kept on overflow", v, 32'h0010_1010);

      // R4: underrun
      rx_read(v);
      check_eq("R4", "empty read data", v, 32'h0);
      peek(4'd5, v);
      check_eq("R4", "underrun flag", (v >> 16) & 32'h1, 32'h1);

      // R7: write all ones clears
      wr(4'd5, 32'hFFFF_FFFF);
      peek(4'd5, v);
      check_eq("R7", "flags after clear", v, 32'h0);

      // R5: thresholds
      wr(4'd1, 32'h2);
      eng_push(32'hA5);
      idle(1);
      peek(4'd5, v);
      check_eq("R5", "rx threshold at 1 word", v, 32'h10);
      wr(4'd1, 32'h1);
      wr(4'd5, 32'hFFFF_FFFF);
      for (int i = 0; i < 12; i++) eng_pop();
      idle(1);
      peek(4'd5, v);
      check_eq("R5", "tx threshold at 4 words", v, 32'h20);

      // R10: independent transmit flush
      wr(4'd0, 32'h1);
      idle(2);
      peek(4'd4, v);
      check_eq("R10", "status after tx flush", v, 32'h0100_0000);
      check_eq("R10", "tx head after flush", eng_tx_data, 32'h0);

      // R7: set wins over clear
      wr(4'd5, 32'hFFFF_FFFF);
      peek(4'd5, v);
      check_eq("R7", "set beats clear", v, 32'h0000_0220);

      // R6: receive fill, drop and order
      for (int i = 0; i < 16; i++) eng_push(32'hB00 + i);
      idle(1);
      peek(4'd4, v);
      check_eq("R6", "status rx full", v, 32'h1000_0000);
      peek(4'd5, v);
      check_eq("R6", "rx full flag", (v >> 8) & 32'h1, 32'h1);
      rx_read(v);
      check_eq("R6", "first rx word", v, 32'hA5);
      rx_read(v);
      check_eq("R6", "second rx word", v, 32'hB00);
      for (int i = 0; i < 14; i++) rx_read(v);
      check_eq("R6", "last rx word", v, 32'hB0E);
      wr(4'd0, 32'h2);

      // R8 / R9: transfer flags and interrupt
      xfer_rx_done = 1'b1; @(negedge clk); xfer_rx_done = 1'b0;
      peek(4'd7, v);
      check_eq("R8", "rx done flag", v, 32'h1);
      check_eq("R9", "irq masked", {31'b0, irq}, 32'h0);
      wr(4'd8, 32'h1);
      check_eq("R9", "irq enabled", {31'b0, irq}, 32'h1);
      xfer_tx_done = 1'b1; @(negedge clk); xfer_tx_done = 1'b0;
      peek(4'd7, v);
      check_eq("R8", "both done flags", v, 32'h3);
      wr(4'd7, 32'h1);
      peek(4'd7, v);
      check_eq("R8", "partial clear", v, 32'h2);
      check_eq("R9", "irq after clear", {31'b0, irq}, 32'h0);
      wr(4'd6, 32'h0000_0200);
      check_eq("R9", "irq from tx empty", {31'b0, irq}, 32'h1);

      idle(2);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule